// File: doc/BRIEF.md
# Link Rate and Lane Count Selector

This block picks the lane count and the link rate for a display link from the mode's pixel clock (in kHz), the bits per colour component, and two capability bytes read earlier from the sink: its maximum link rate code and its maximum lane count byte. Two flags shape the result. One says whether the sink and source may use the 5.4 Gb/s rate. The other marks a bridge that must always run at 2.7 Gb/s.

A search takes two passes. The first pass finds the fewest lanes (1, 2, 4, and so on) that carry the mode at the sink's maximum rate, and it stops at the sink's lane limit. With those lanes fixed, the second pass takes the lowest standard rate that fits. A mode that ends up at 5.4 Gb/s without the flag that allows it is marked as clock-too-high. The block tests one candidate per clock cycle. It uses no divider: it compares `pixel_clock * bpp` against `rate * lanes * 8`.

A request is launched with a one-cycle `start`. The result registers hold their values until the next request completes, and a one-cycle `done` pulse marks each new result.

Top module: `lrs_link_sel`

## Requirements
- R1: Bits per pixel is 24 when `bpc` is 0; for any other value it is `3 * bpc`.
- R2: A configuration fits when `pix_khz * bpp <= rate_khz * lanes * 8`. Equality counts as a fit.
- R3: The lane count starts at 1 and doubles while it is below the sink's lane limit and the mode does not fit at the sink's maximum rate. The lane limit is bits [4:0] of `cap_lane_byte`; bits [7:5] are ignored.
- R4: The sink's maximum rate is 270000 kHz for code 0x0A and 540000 kHz for code 0x14. Every other code, 0x06 included, means 162000 kHz.
- R5: With the lanes from R3, the rate is the first of 162000, 270000 and 540000 kHz that fits. 540000 is a candidate only when `hbr2_ok` is 1. When no candidate fits, the rate is the sink's maximum rate.
- R6: When `bridge` is 1, the rate is 270000 kHz. The lane count is still found as in R3.
- R7: `clk_too_high` is 1 exactly when the chosen rate is 540000 kHz and `hbr2_ok` is 0.
- R8: `link_code` carries the chosen rate as a code: 0x06 for 162000, 0x0A for 270000 and 0x14 for 540000.
- R9: `done` is a one-cycle pulse, `L + R` cycles after the edge that accepts `start`. L is the number of lane candidates tried. R is 1 for a bridge or when 162000 fits, 2 when 270000 is the first fit, and 3 otherwise.
- R10: `start` is ignored while `busy` is 1. An ignored `start` produces no `done` pulse and leaves the request in progress unchanged. The outputs hold their values between `done` pulses.
- R11: After reset, `busy`, `done`, `lane_cnt`, `link_khz`, `link_code` and `clk_too_high` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, accepted while idle |
| pix_khz | input | 20 | Pixel clock in kHz |
| bpc | input | 4 | Bits per colour component; 0 means 8 |
| cap_rate_code | input | 8 | Sink maximum link rate code |
| cap_lane_byte | input | 8 | Sink lane count byte; lane limit in bits [4:0] |
| hbr2_ok | input | 1 | 5.4 Gb/s allowed |
| bridge | input | 1 | Bridge present: force 2.7 Gb/s |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse: a new result is valid |
| lane_cnt | output | 6 | Selected lane count |
| link_khz | output | 20 | Selected link rate in kHz |
| link_code | output | 8 | Selected link rate code |
| clk_too_high | output | 1 | Mode needs 5.4 Gb/s without permission |

## Verification
For every request, the bench works out how many lane candidates (L) and how many rate candidates (R) the search tries. It expects the result exactly `L + R` cycles after the edge that samples `start`. A scoreboard entry holds the expected lanes, rate, code, flag and due cycle. The monitor samples on falling edges, so it reads registered outputs half a cycle after they change. It compares the cycle count at each `done` with the due cycle. It reports any `done` that arrives with no request outstanding, which is how an extra result from an ignored `start` is caught.

// File: rtl/lrs_pkg.sv
package lrs_pkg;

    localparam int PIX_W  = 20;
    localparam int BPC_W  = 4;
    localparam int BPP_W  = 6;
    localparam int RATE_W = 20;
    localparam int LANE_W = 6;
    localparam int CODE_W = 8;

    localparam logic [CODE_W-1:0] CODE_RBR  = 8'h06;
    localparam logic [CODE_W-1:0] CODE_HBR  = 8'h0A;
    localparam logic [CODE_W-1:0] CODE_HBR2 = 8'h14;

    localparam logic [RATE_W-1:0] KHZ_RBR  = RATE_W'(162000);
    localparam logic [RATE_W-1:0] KHZ_HBR  = RATE_W'(270000);
    localparam logic [RATE_W-1:0] KHZ_HBR2 = RATE_W'(540000);

    localparam int LANE_FIELD_W = 5;

    typedef enum logic [1:0] {
        STEP_RBR  = 2'd0,
        STEP_HBR  = 2'd1,
        STEP_HBR2 = 2'd2
    } rate_step_e;

    typedef struct packed {
        logic [PIX_W-1:0]  pix;
        logic [BPP_W-1:0]  bpp;
        logic [RATE_W-1:0] max_khz;
        logic [LANE_W-1:0] max_lanes;
        logic              hbr2;
        logic              bridge;
    } req_t;

    typedef struct packed {
        logic [LANE_W-1:0] lanes;
        logic [RATE_W-1:0] khz;
        logic [CODE_W-1:0] code;
        logic              too_high;
    } res_t;

    function automatic logic [BPP_W-1:0] bpp_of(input logic [BPC_W-1:0] bpc);
        if (bpc == '0) return BPP_W'(24);
        return BPP_W'(BPP_W'(bpc) * BPP_W'(3));
    endfunction

    function automatic logic [RATE_W-1:0] khz_of_code(input logic [CODE_W-1:0] code);
        case (code)
            CODE_HBR:  return KHZ_HBR;
            CODE_HBR2: return KHZ_HBR2;
            default:   return KHZ_RBR;
        endcase
    endfunction

    function automatic logic [CODE_W-1:0] code_of_khz(input logic [RATE_W-1:0] khz);
        case (khz)
            KHZ_HBR:  return CODE_HBR;
            KHZ_HBR2: return CODE_HBR2;
            default:  return CODE_RBR;
        endcase
    endfunction

    function automatic logic [LANE_W-1:0] lanes_of_cap(input logic [CODE_W-1:0] cap);
        return LANE_W'(cap[LANE_FIELD_W-1:0]);
    endfunction

endpackage

// File: rtl/lrs_fit_cmp.sv
module lrs_fit_cmp #(
    parameter int PIX_W  = 20,
    parameter int BPP_W  = 6,
    parameter int RATE_W = 20,
    parameter int LANE_W = 6
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [BPP_W-1:0]  bpp,
    input  logic [RATE_W-1:0] rate_khz,
    input  logic [LANE_W-1:0] lanes,
    output logic              fits
);
    localparam int DEM_W = PIX_W + BPP_W;
    localparam int SUP_W = RATE_W + LANE_W + 3;
    localparam int CMP_W = ((DEM_W > SUP_W) ? DEM_W : SUP_W) + 1;

    logic [CMP_W-1:0] demand;
    logic [CMP_W-1:0] supply;

    // Wide multiply-compare replaces the divide in rate*lanes*8/bpp
    always_comb begin
        demand = CMP_W'(pix) * CMP_W'(bpp);
        supply = (CMP_W'(rate_khz) * CMP_W'(lanes)) << 3;
        fits   = (demand <= supply);
    end
endmodule

// File: rtl/lrs_lane_walk.sv
module lrs_lane_walk #(
    parameter int PIX_W  = 20,
    parameter int BPP_W  = 6,
    parameter int RATE_W = 20,
    parameter int LANE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [PIX_W-1:0]  pix,
    input  logic [BPP_W-1:0]  bpp,
    input  logic [RATE_W-1:0] max_khz,
    input  logic [LANE_W-1:0] max_lanes,
    output logic [LANE_W-1:0] lanes,
    output logic              fin
);
    logic [LANE_W-1:0] lanes_q;
    logic              act_q;
    logic              fits_max;

    lrs_fit_cmp #(
        .PIX_W(PIX_W), .BPP_W(BPP_W), .RATE_W(RATE_W), .LANE_W(LANE_W)
    ) u_fit (
        .pix(pix), .bpp(bpp), .rate_khz(max_khz), .lanes(lanes_q), .fits(fits_max)
    );

    assign fin   = act_q && (fits_max || (lanes_q >= max_lanes));
    assign lanes = lanes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_q <= '0;
            act_q   <= 1'b0;
        end else if (go) begin
            lanes_q <= LANE_W'(1);
            act_q   <= 1'b1;
        end else if (act_q) begin
            if (fin) act_q <= 1'b0;
            else     lanes_q <= lanes_q << 1;
        end
    end

    // R3
    lane_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fin && (lanes_q > LANE_W'(1)) |-> ((lanes_q >> 1) < max_lanes));

    // R3
    lane_step_chk: assert property (@(posedge clk) disable iff (rst)
        act_q && !fin && !go |=> lanes_q == ($past(lanes_q) << 1));
endmodule

// File: rtl/lrs_rate_walk.sv
module lrs_rate_walk
    import lrs_pkg::*;
#(
    parameter int PIX_W  = 20,
    parameter int BPP_W  = 6,
    parameter int RATE_W = 20,
    parameter int LANE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [PIX_W-1:0]  pix,
    input  logic [BPP_W-1:0]  bpp,
    input  logic [LANE_W-1:0] lanes,
    input  logic [RATE_W-1:0] max_khz,
    input  logic              hbr2,
    input  logic              bridge,
    output logic [RATE_W-1:0] khz,
    output logic              fin
);
    rate_step_e        step_q;
    logic              act_q;
    logic [RATE_W-1:0] cand_khz;
    logic              cand_fits;

    always_comb begin
        case (step_q)
            STEP_RBR:  cand_khz = KHZ_RBR;
            STEP_HBR:  cand_khz = KHZ_HBR;
            default:   cand_khz = KHZ_HBR2;
        endcase
    end

    lrs_fit_cmp #(
        .PIX_W(PIX_W), .BPP_W(BPP_W), .RATE_W(RATE_W), .LANE_W(LANE_W)
    ) u_fit (
        .pix(pix), .bpp(bpp), .rate_khz(cand_khz), .lanes(lanes), .fits(cand_fits)
    );

    always_comb begin
        fin = 1'b0;
        khz = cand_khz;
        if (act_q) begin
            if (bridge) begin
                fin = 1'b1;
                khz = KHZ_HBR;
            end else if (step_q == STEP_HBR2) begin
                fin = 1'b1;
                khz = (hbr2 && cand_fits) ? KHZ_HBR2 : max_khz;
            end else begin
                fin = cand_fits;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= STEP_RBR;
            act_q  <= 1'b0;
        end else if (go) begin
            step_q <= STEP_RBR;
            act_q  <= 1'b1;
        end else if (act_q) begin
            if (fin) act_q <= 1'b0;
            else if (step_q == STEP_RBR) step_q <= STEP_HBR;
            else step_q <= STEP_HBR2;
        end
    end

    // R5
    hbr2_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fin && !hbr2 && (khz == KHZ_HBR2) |-> (max_khz == KHZ_HBR2));

    // R5
    step_order_chk: assert property (@(posedge clk) disable iff (rst)
        act_q && !fin && !go |=> act_q && (step_q != STEP_RBR));
endmodule

// File: rtl/lrs_link_sel.sv
module lrs_link_sel
    import lrs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [19:0]       pix_khz,
    input  logic [3:0]        bpc,
    input  logic [7:0]        cap_rate_code,
    input  logic [7:0]        cap_lane_byte,
    input  logic              hbr2_ok,
    input  logic              bridge,
    output logic              busy,
    output logic              done,
    output logic [5:0]        lane_cnt,
    output logic [19:0]       link_khz,
    output logic [7:0]        link_code,
    output logic              clk_too_high
);
    req_t              req_q;
    req_t              req_d;
    res_t              res_q;
    res_t              res_d;
    logic              busy_q;
    logic              done_q;
    logic              accept;
    logic              lane_fin;
    logic              rate_fin;
    logic [LANE_W-1:0] walk_lanes;
    logic [RATE_W-1:0] walk_khz;

    assign accept = start && !busy_q;

    always_comb begin
        req_d.pix       = pix_khz;
        req_d.bpp       = bpp_of(bpc);
        req_d.max_khz   = khz_of_code(cap_rate_code);
        req_d.max_lanes = lanes_of_cap(cap_lane_byte);
        req_d.hbr2      = hbr2_ok;
        req_d.bridge    = bridge;
    end

    lrs_lane_walk #(
        .PIX_W(PIX_W), .BPP_W(BPP_W), .RATE_W(RATE_W), .LANE_W(LANE_W)
    ) u_lanes (
        .clk(clk), .rst(rst), .go(accept),
        .pix(req_q.pix), .bpp(req_q.bpp),
        .max_khz(req_q.max_khz), .max_lanes(req_q.max_lanes),
        .lanes(walk_lanes), .fin(lane_fin)
    );

    lrs_rate_walk #(
        .PIX_W(PIX_W), .BPP_W(BPP_W), .RATE_W(RATE_W), .LANE_W(LANE_W)
    ) u_rates (
        .clk(clk), .rst(rst), .go(lane_fin),
        .pix(req_q.pix), .bpp(req_q.bpp), .lanes(walk_lanes),
        .max_khz(req_q.max_khz), .hbr2(req_q.hbr2), .bridge(req_q.bridge),
        .khz(walk_khz), .fin(rate_fin)
    );

    always_comb begin
        res_d.lanes    = walk_lanes;
        res_d.khz      = walk_khz;
        res_d.code     = code_of_khz(walk_khz);
        res_d.too_high = (walk_khz == KHZ_HBR2) && !req_q.hbr2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            res_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= rate_fin;
            if (accept) begin
                req_q  <= req_d;
                busy_q <= 1'b1;
            end else if (rate_fin) begin
                busy_q <= 1'b0;
            end
            if (rate_fin) res_q <= res_d;
        end
    end

    assign busy         = busy_q;
    assign done         = done_q;
    assign lane_cnt     = res_q.lanes;
    assign link_khz     = res_q.khz;
    assign link_code    = res_q.code;
    assign clk_too_high = res_q.too_high;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> $stable(req_q));

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rate_fin |=> $stable(res_q));

    // R6
    bridge_rate_chk: assert property (@(posedge clk) disable iff (rst)
        done_q && req_q.bridge |-> (link_khz == KHZ_HBR));

    // R8
    code_pair_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ((link_code == CODE_RBR  && link_khz == KHZ_RBR) ||
                    (link_code == CODE_HBR  && link_khz == KHZ_HBR) ||
                    (link_code == CODE_HBR2 && link_khz == KHZ_HBR2)));

    // R3
    lane_pow2_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($countones(lane_cnt) == 1));
endmodule

// File: tb/lrs_link_sel_tb.sv
module lrs_link_sel_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [19:0] pix_khz = '0;
    logic [3:0]  bpc = '0;
    logic [7:0]  cap_rate_code = '0;
    logic [7:0]  cap_lane_byte = '0;
    logic        hbr2_ok = 1'b0;
    logic        bridge = 1'b0;
    logic        busy, done, clk_too_high;
    logic [5:0]  lane_cnt;
    logic [19:0] link_khz;
    logic [7:0]  link_code;

    typedef struct {
        int     lanes;
        int     khz;
        int     code;
        bit     th;
        longint due;
        string  tag;
    } exp_t;

    exp_t   sb[$];
    exp_t   last_exp;
    int     n_checks = 0;
    int     n_errors = 0;
    longint cyc = 0;
    bit     finished = 0;

    lrs_link_sel u_dut (
        .clk(clk), .rst(rst), .start(start), .pix_khz(pix_khz), .bpc(bpc),
        .cap_rate_code(cap_rate_code), .cap_lane_byte(cap_lane_byte),
        .hbr2_ok(hbr2_ok), .bridge(bridge), .busy(busy), .done(done),
        .lane_cnt(lane_cnt), .link_khz(link_khz), .link_code(link_code),
        .clk_too_high(clk_too_high)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    task automatic chk(input string tag, input longint got, input longint exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic bit fit_m(longint pix, longint bpp, longint rate, longint lanes);
        return (pix * bpp) <= (rate * lanes * 8);
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                n_checks++;
                n_errors++;
                $display("FAIL R10 stray done: got 1 expected 0");
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R3 lanes", lane_cnt, e.lanes);
                chk({e.tag, " rate"}, link_khz, e.khz);
                chk("R8 code", link_code, e.code);
                chk("R7 too_high", clk_too_high, e.th);
                chk("R9 latency", cyc, e.due);
                last_exp = e;
            end
        end
    end

    task automatic run_case(input int pix, input int bc, input int rc, input int lb,
                            input bit h2, input bit br, input string tag,
                            input bit intrude);
        exp_t e;
        int bpp, maxk, maxl, lanes, L, R, rate;
        bpp  = (bc == 0) ? 24 : 3 * bc;
        maxk = (rc == 8'h0A) ? 270000 : (rc == 8'h14) ? 540000 : 162000;
        maxl = lb & 31;
        lanes = 1; L = 1;
        while (lanes < maxl && !fit_m(pix, bpp, maxk, lanes)) begin
            lanes = lanes * 2;
            L++;
        end
        if (br) begin rate = 270000; R = 1; end
        else if (fit_m(pix, bpp, 162000, lanes)) begin rate = 162000; R = 1; end
        else if (fit_m(pix, bpp, 270000, lanes)) begin rate = 270000; R = 2; end
        else begin
            R = 3;
            rate = (h2 && fit_m(pix, bpp, 540000, lanes)) ? 540000 : maxk;
        end
        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        pix_khz = 20'(pix); bpc = 4'(bc); cap_rate_code = 8'(rc);
        cap_lane_byte = 8'(lb); hbr2_ok = h2; bridge = br; start = 1'b1;
        e.lanes = lanes; e.khz = rate;
        e.code = (rate == 270000) ? 8'h0A : (rate == 540000) ? 8'h14 : 8'h06;
        e.th = (rate == 540000) && !h2;
        e.due = cyc + 1 + L + R;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        if (intrude) begin
            // R10: a second request while busy must be ignored
            pix_khz = 20'd1000; bpc = 4'd6; cap_rate_code = 8'h06;
            cap_lane_byte = 8'h01; hbr2_ok = 1'b0; bridge = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R11 reset state
        chk("R11 busy", busy, 0);
        chk("R11 done", done, 0);
        chk("R11 lanes", lane_cnt, 0);
        chk("R11 khz", link_khz, 0);
        chk("R11 code", link_code, 0);
        chk("R11 too_high", clk_too_high, 0);
        rst = 1'b0;

        run_case(100000, 8, 8'h0A, 8'h84, 0, 0, "R3", 0);
        run_case(100000, 10, 8'h0A, 8'h04, 0, 0, "R2", 0);
        run_case(500000, 8, 8'h14, 8'h04, 1, 0, "R5", 0);
        run_case(500000, 8, 8'h14, 8'h04, 0, 0, "R7", 0);
        run_case(100000, 8, 8'h0A, 8'h04, 0, 1, "R6", 0);
        run_case(300000, 8, 8'h33, 8'h02, 0, 0, "R4", 0);
        run_case(400000, 8, 8'h06, 8'h00, 1, 0, "R3", 0);
        run_case(400000, 8, 8'h06, 8'h03, 0, 0, "R3", 0);
        run_case(150000, 0, 8'h0A, 8'h04, 0, 0, "R1", 0);
        run_case(150000, 8, 8'h0A, 8'h04, 0, 0, "R1", 0);
        run_case(108000, 8, 8'h06, 8'h04, 0, 0, "R2", 0);
        run_case(108001, 8, 8'h06, 8'h04, 0, 0, "R2", 0);
        run_case(600000, 12, 8'h14, 8'h04, 1, 1, "R6", 0);

        // R10: request arriving while busy
        run_case(500000, 8, 8'h14, 8'h04, 1, 0, "R10", 1);
        repeat (10) @(negedge clk);
        chk("R10 hold lanes", lane_cnt, last_exp.lanes);
        chk("R10 hold khz", link_khz, last_exp.khz);
        chk("R10 hold busy", busy, 0);

        for (int b = 0; b <= 12; b += 2) begin
            for (int p = 50000; p <= 650000; p += 150000) begin
                run_case(p, b, (p % 3 == 0) ? 8'h14 : 8'h0A, 8'h04, (b % 4 == 0), 0, "R5", 0);
            end
        end

        repeat (5) @(negedge clk);
        finished = 1;
        summary();
    end
endmodule